// File: doc/BRIEF.md
# PLL Divider Search Engine

This engine turns a requested clock frequency, given in kHz, into the three integer settings of a phase-locked loop: a post divider applied after the oscillator, a reference predivider and a feedback multiplier. A start pulse latches the request. The engine first picks the post divider so that the oscillator lands inside its legal band. It then tries every reference predivider in turn and keeps the one whose rounded multiplier brings the oscillator closest to its target.

All quotients come from one shared radix-2 restoring divider that takes 32 cycles per division. For this reason, a search over the full predivider range takes a few thousand cycles. When the search ends, a single-cycle `done` pulse appears together with either `ok` or `err`. On success the three divider outputs load the chosen values. On failure they keep the last good result.

Top module: `pll_div_search`

## Requirements
- R1: A start with `freq_khz` equal to 0 gives `done` and `err` on the clock edge that accepts the start, and runs no search.
- R2: The post divider `no` is the ceiling of 440000 divided by the request. If that value is above 1, it is raised to the next even number. A value above 16 ends the run with `err`.
- R3: The oscillator target, request times `no`, must lie in 440000..2200000 kHz inclusive. Otherwise the run ends with `err`.
- R4: The predivider `nr` is tried from 1 to 63, with reference step REF_KHZ / `nr` (REF_KHZ defaults to 24000). `nf` is the target divided by the step. It is raised by one when the remainder is more than half the step and `nf`+1 stays below 4096; candidates with `nf` of 4096 or more are dropped. The closest candidate wins, and the sweep ends early on an exact hit.
- R5: A later candidate replaces the kept one only if its error is strictly smaller, so among equal errors the lowest `nr` wins.
- R6: Reference steps above 2200000 kHz are not tried. A final error above 4000 kHz gives `err`. With REF_KHZ set to 150000000, every step is skipped and any legal request fails.
- R7: `done` lasts one cycle, with exactly one of `ok`/`err` set. Both flags then hold until the next accepted start, which clears them.
- R8: A start that arrives while a search is running is ignored and does not change that search's result.
- R9: `nr`, `nf` and `no` change only on the `done` of a successful run, and otherwise hold their values.
- R10: After reset, `done`, `ok`, `err`, `nr`, `nf` and `no` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled when idle |
| freq_khz | input | 32 | Requested output frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last run found a setting |
| err | output | 1 | Last run failed |
| nr | output | 6 | Chosen reference predivider |
| nf | output | 12 | Chosen feedback multiplier |
| no | output | 5 | Chosen post divider |

## Verification
The checker rebuilds the busy state from the ports alone, so it assumes that a request is accepted only in the cycle after `done` or when nothing is running. The pulse property also assumes that no zero-frequency start is issued on the very cycle `done` is high. The bench keeps inside these limits: it waits one idle cycle after every `done` before pulsing `start` again, and it sends its only mid-run start with a nonzero frequency.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int unsigned W        = 32,
  parameter int unsigned REF_KHZ  = 24000,
  parameter int unsigned VCO_MIN  = 440000,
  parameter int unsigned VCO_MAX  = 2200000,
  parameter int unsigned FREF_MIN = 269,
  parameter int unsigned FREF_MAX = 2200000,
  parameter int unsigned ERR_MAX  = 4000,
  parameter int unsigned NR_LIM   = 64,
  parameter int unsigned NF_LIM   = 4096,
  parameter int unsigned NO_LIM   = 16,
  localparam int unsigned NRW = $clog2(NR_LIM),
  localparam int unsigned NFW = $clog2(NF_LIM),
  localparam int unsigned NOW = $clog2(NO_LIM) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   freq_khz,
  output logic           done,
  output logic           ok,
  output logic           err,
  output logic [NRW-1:0] nr,
  output logic [NFW-1:0] nf,
  output logic [NOW-1:0] no
);
  localparam int unsigned CW = $clog2(W) + 1;
  localparam int unsigned PW = W + NOW;

  typedef enum logic [2:0] {IDLE, GET_NO, GET_REF, GET_NF, FIN} st_t;
  st_t st;

  logic [W-1:0]   dq, dvs, freq_r, vco, fref, best;
  logic [W:0]     drem;
  logic [CW-1:0]  dcnt;
  logic [NRW-1:0] cur_nr, bnr;
  logic [NFW-1:0] bnf;
  logic [NOW-1:0] no_r;

  wire         dbusy = dcnt != '0;
  wire [W:0]   trial = {drem[W-1:0], dq[W-1]} - {1'b0, dvs};

  wire [W-1:0] no_raw = dq + W'(drem != '0);
  wire [W-1:0] no_c   = (no_raw > W'(1) && no_raw[0]) ? no_raw + W'(1) : no_raw;
  wire [PW-1:0] vco_c = PW'(freq_r) * PW'(no_c[NOW-1:0]);
  wire         no_bad = no_c > W'(NO_LIM);
  wire         vco_bad = vco_c < PW'(VCO_MIN) || vco_c > PW'(VCO_MAX);

  wire [W-1:0] rmd    = drem[W-1:0];
  wire         nf_big = dq >= W'(NF_LIM);
  wire         rnd    = (dq + W'(1) < W'(NF_LIM)) && (rmd > (fref >> 1));
  wire [W-1:0] diff   = rnd ? fref - rmd : rmd;
  wire [W-1:0] nf_c   = rnd ? dq + W'(1) : dq;
  wire         better = !nf_big && diff < best;
  wire         last   = cur_nr == NRW'(NR_LIM - 1);
  wire         stop   = (better && diff == '0) || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      nr <= '0; nf <= '0; no <= '0;
      dq <= '0; dvs <= '0; drem <= '0; dcnt <= '0;
      freq_r <= '0; vco <= '0; fref <= '0; best <= '0;
      cur_nr <= '0; bnr <= '0; bnf <= '0; no_r <= '0;
    end else begin
      done <= 1'b0;
      if (dbusy) begin
        dcnt <= dcnt - CW'(1);
        if (!trial[W]) begin
          drem <= trial;
          dq   <= {dq[W-2:0], 1'b1};
        end else begin
          drem <= {drem[W-1:0], dq[W-1]};
          dq   <= {dq[W-2:0], 1'b0};
        end
      end
      case (st)
        IDLE: if (start) begin
          ok <= 1'b0; err <= 1'b0;
          if (freq_khz == '0) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            freq_r <= freq_khz;
            dq <= W'(VCO_MIN); dvs <= freq_khz; drem <= '0; dcnt <= CW'(W);
            st <= GET_NO;
          end
        end
        GET_NO: if (!dbusy) begin
          if (no_bad || vco_bad) begin
            done <= 1'b1; err <= 1'b1; st <= IDLE;
          end else begin
            no_r <= no_c[NOW-1:0];
            vco  <= vco_c[W-1:0];
            best <= vco_c[W-1:0];
            cur_nr <= NRW'(1);
            dq <= W'(REF_KHZ); dvs <= W'(1); drem <= '0; dcnt <= CW'(W);
            st <= GET_REF;
          end
        end
        GET_REF: if (!dbusy) begin
          fref <= dq;
          if (dq < W'(FREF_MIN)) begin
            st <= FIN;
          end else if (dq > W'(FREF_MAX)) begin
            if (last) st <= FIN;
            else begin
              cur_nr <= cur_nr + NRW'(1);
              dq <= W'(REF_KHZ); dvs <= W'(cur_nr) + W'(1); drem <= '0; dcnt <= CW'(W);
            end
          end else begin
            dq <= vco; dvs <= dq; drem <= '0; dcnt <= CW'(W);
            st <= GET_NF;
          end
        end
        GET_NF: if (!dbusy) begin
          if (better) begin
            best <= diff; bnr <= cur_nr; bnf <= nf_c[NFW-1:0];
          end
          if (stop) st <= FIN;
          else begin
            cur_nr <= cur_nr + NRW'(1);
            dq <= W'(REF_KHZ); dvs <= W'(cur_nr) + W'(1); drem <= '0; dcnt <= CW'(W);
            st <= GET_REF;
          end
        end
        FIN: begin
          done <= 1'b1;
          if (best <= W'(ERR_MAX)) begin
            ok <= 1'b1; nr <= bnr; nf <= bnf; no <= no_r;
          end else begin
            err <= 1'b1;
          end
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned NR_LIM = 64,
  parameter int unsigned NF_LIM = 4096,
  parameter int unsigned NO_LIM = 16,
  localparam int unsigned NRW = $clog2(NR_LIM),
  localparam int unsigned NFW = $clog2(NF_LIM),
  localparam int unsigned NOW = $clog2(NO_LIM) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   freq_khz,
  input logic           done,
  input logic           ok,
  input logic           err,
  input logic [NRW-1:0] nr,
  input logic [NFW-1:0] nf,
  input logic [NOW-1:0] no
);
  logic run;
  wire acc = start && (!run || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else if (acc && freq_khz != '0) run <= 1'b1;
    else if (done) run <= 1'b0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R7
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err)); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && freq_khz != '0 |=> !ok && !err && !done); // R7
  AST_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && freq_khz == '0 |=> done && err); // R1
  AST_NO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> no != '0 && 32'(no) <= NO_LIM && (no == NOW'(1) || !no[0])); // R2
  AST_NR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> nr != '0 && 32'(nr) <= NR_LIM - 1); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(nr) && $stable(nf) && $stable(no)); // R9
endmodule

bind pll_div_search pll_div_search_chk #(.W(W), .NR_LIM(NR_LIM), .NF_LIM(NF_LIM), .NO_LIM(NO_LIM)) u_chk (.*);

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, start2 = 1'b0;
  logic [31:0] freq = '0, freq2 = '0;
  logic done, ok, err, done2, ok2, err2;
  logic [5:0] nr, nr2;
  logic [11:0] nf, nf2;
  logic [4:0] no, no2;
  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  pll_div_search dut (.clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq),
    .done(done), .ok(ok), .err(err), .nr(nr), .nf(nf), .no(no));
  pll_div_search #(.REF_KHZ(150000000)) dut_far (.clk(clk), .rst_n(rst_n), .start(start2),
    .freq_khz(freq2), .done(done2), .ok(ok2), .err(err2), .nr(nr2), .nf(nf2), .no(no2));

  // freq, expect ok, nr, nf, no, requirement
  localparam int unsigned VEC [9][6] = '{
    '{148500,  1, 4, 99,  4, 4},  // R4 rounding then exact hit
    '{20000,   0, 0, 0,   0, 2},  // R2 post divider 22 > 16
    '{100000,  1, 1, 25,  6, 2},  // R2 ceil 5 -> even 6
    '{27499,   0, 0, 0,   0, 2},  // R2 17 -> 18 > 16
    '{1000000, 1, 3, 125, 1, 4},  // R4
    '{2200001, 0, 0, 0,   0, 3},  // R3 above band
    '{27500,   1, 3, 55, 16, 2},  // R2 exactly 16
    '{2200000, 1, 3, 275, 1, 3},  // R3 top of band
    '{440001,  1, 3, 55,  1, 5}   // R5 tie at nr=6 keeps nr=3
  };

  task automatic chk(input bit c, input string tag, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] f);
    freq = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(1'b0, "watchdog", n, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned hnr = 0, hnf = 0, hno = 0;
    repeat (3) @(negedge clk);
    chk(!done && !ok && !err, "R10 flags", {done, ok, err}, 0);
    chk(nr == 0 && nf == 0 && no == 0, "R10 outputs", {nr, nf, no}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      pulse(VEC[i][0]);
      wait_done(n);
      chk(ok == VEC[i][1][0] && err == !VEC[i][1][0], $sformatf("R%0d flag f=%0d", VEC[i][5], VEC[i][0]), ok, VEC[i][1]);
      if (VEC[i][1] != 0) begin hnr = VEC[i][2]; hnf = VEC[i][3]; hno = VEC[i][4]; end
      chk(nr == hnr && nf == hnf, $sformatf("R%0d nr/nf f=%0d", VEC[i][5], VEC[i][0]), {nr, nf}, {hnr[5:0], hnf[11:0]});
      chk(no == hno, $sformatf("R%0d no f=%0d (R9 hold on err)", VEC[i][5], VEC[i][0]), no, hno);
      @(negedge clk);
      chk(!done && ok == VEC[i][1][0], "R7 pulse and held flag", {done, ok}, {1'b0, VEC[i][1][0]});
    end

    // R1: zero request answers on the accepting edge
    pulse(0);
    chk(done && err && !ok, "R1 zero", {done, err, ok}, 3'b110);
    chk(nr == 3 && nf == 55 && no == 1, "R9 hold on zero", {nr, nf, no}, {6'd3, 12'd55, 5'd1});
    @(negedge clk);

    // R7: flags cleared by a new start
    pulse(100000);
    @(negedge clk);
    chk(!ok && !err, "R7 clear on start", {ok, err}, 0);
    wait_done(n);
    chk(ok && nr == 1 && nf == 25 && no == 6, "R7 rerun result", {ok, nr, nf, no}, {1'b1, 6'd1, 12'd25, 5'd6});
    @(negedge clk);

    // R8: start while busy is ignored
    pulse(148500);
    repeat (5) @(negedge clk);
    pulse(1000000);
    wait_done(n);
    chk(ok && nr == 4 && nf == 99 && no == 4, "R8 busy start ignored", {nr, nf, no}, {6'd4, 12'd99, 5'd4});
    n = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); if (done) n++; end
    chk(n == 0, "R8 no second run", n, 0);

    // R6: every reference step too high -> error
    freq2 = 100000; start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    n = 0;
    while (!done2 && n < 20000) begin @(negedge clk); n++; end
    chk(done2 && err2 && !ok2, "R6 error bound", {done2, err2, ok2}, 3'b110);
    chk(nr2 == 0 && nf2 == 0 && no2 == 0, "R6 outputs untouched", {nr2, nf2, no2}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule